// File: doc/BRIEF.md
# Pointer and Working Register Exchange Unit

This block keeps the 4-bit accumulator, the two nibbles of the data pointer (high and low), and a bank of working registers: four accumulator spares, two spares for the high pointer nibble and two for the low one. Each clock cycle it performs one operation, given by an operation code, a register selector and a 4-bit immediate. The operations are immediate loads of the pointer, increment and decrement of the low pointer nibble, swaps between the live registers and their spares, a swap of accumulator and high nibble, and copies in both directions between accumulator and low nibble.

Every register the operation writes changes on the same rising clock edge. A swap therefore reads both old values and writes both new values at once. A zero flag shows whether the last increment or decrement produced zero. No other operation changes the flag. A surrounding instruction sequencer drives the operation code, and arithmetic, memory access and decoding of instructions stay outside this block.

Top module: `ptr_xchg_unit`

## Requirements
- R1: While rstN is low, every register output and zeroFlag read 0.
- R2: Operation code 1 (load-zero) writes 0 to dphOut and immData to dplOut.
- R3: Operation code 2 (load-high) writes immData to dphOut. dplOut keeps its value.
- R4: Operation code 3 (increment) sets dplOut to (dplOut+1) mod 16. zeroFlag goes to 1 exactly when that result is 0.
- R5: Operation code 4 (decrement) sets dplOut to (dplOut-1) mod 16. zeroFlag goes to 1 exactly when that result is 0.
- R6: Operation code 5 swaps acOut with spare A[regSel]. Spare A[i] is aRegs[4i+3:4i].
- R7: Operation code 6 swaps dphOut with spare H[regSel[0]], where H[i] is hRegs[4i+3:4i]. regSel[1] has no effect.
- R8: Operation code 7 swaps dplOut with spare L[regSel[0]], where L[i] is lRegs[4i+3:4i]. regSel[1] has no effect.
- R9: Operation code 8 swaps acOut and dphOut.
- R10: Operation code 9 copies acOut into dplOut. Operation code 10 copies dplOut into acOut.
- R11: zeroFlag changes only on operation codes 3 and 4.
- R12: Operation codes 0 and 11 to 15 change no output.
- R13: Each operation shows on the outputs after the rising edge that samples it. No register written by that operation shows a partly updated value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opCode | input | 4 | Operation code |
| regSel | input | 2 | Selector for the spare register |
| immData | input | 4 | Immediate nibble |
| acOut | output | 4 | Accumulator |
| dphOut | output | 4 | Data pointer high nibble |
| dplOut | output | 4 | Data pointer low nibble |
| aRegs | output | 16 | Accumulator spares A0..A3, packed |
| hRegs | output | 8 | High-nibble spares H0..H1, packed |
| lRegs | output | 8 | Low-nibble spares L0..L1, packed |
| zeroFlag | output | 1 | Zero result of the last increment or decrement |

## Verification
A random stream of operation codes, selectors and immediates covers all sixteen codes. It swaps data back and forth through every spare, which shows whether a write lands on the wrong spare or a swap loses one side. Directed runs increment from 15, decrement from 0 and step onto zero. These cases separate a correct modulo-16 wrap and zero flag from an off-by-one or an unwrapped result. Other runs drive regSel[1] high for the one-bit swaps, and some put load, copy or swap codes between increments to confirm the flag holds. Unused codes arrive with random selectors and immediates to confirm they have no effect.

// File: rtl/ptr_xchg_pkg.sv
package ptr_xchg_pkg;
  localparam int DATA_W = 4;
  localparam int A_CNT  = 4;
  localparam int HL_CNT = 2;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_LOADZ  = 4'd1,
    OP_LOADH  = 4'd2,
    OP_INC    = 4'd3,
    OP_DEC    = 4'd4,
    OP_SWAPA  = 4'd5,
    OP_SWAPH  = 4'd6,
    OP_SWAPL  = 4'd7,
    OP_SWAPAH = 4'd8,
    OP_AC2L   = 4'd9,
    OP_L2AC   = 4'd10
  } op_e;

  typedef enum logic [1:0] {AC_HOLD, AC_FROM_A, AC_FROM_DPH, AC_FROM_DPL} ac_src_e;
  typedef enum logic [2:0] {DH_HOLD, DH_ZERO, DH_IMM, DH_FROM_AC, DH_FROM_H} dph_src_e;
  typedef enum logic [2:0] {DL_HOLD, DL_IMM, DL_INC, DL_DEC, DL_FROM_AC, DL_FROM_L} dpl_src_e;

  typedef struct packed {
    ac_src_e  acSrc;
    dph_src_e dphSrc;
    dpl_src_e dplSrc;
    logic     aWr;
    logic     hWr;
    logic     lWr;
    logic     zfWr;
  } strobe_t;
endpackage

// File: rtl/ptr_xchg_ctrl.sv
module ptr_xchg_ctrl
  import ptr_xchg_pkg::*;
(
  input  logic [3:0] opCode,
  output strobe_t    st
);
  always_comb begin
    st = '{acSrc: AC_HOLD, dphSrc: DH_HOLD, dplSrc: DL_HOLD,
           aWr: 1'b0, hWr: 1'b0, lWr: 1'b0, zfWr: 1'b0};
    case (opCode)
      OP_LOADZ:  begin st.dphSrc = DH_ZERO; st.dplSrc = DL_IMM; end
      OP_LOADH:  st.dphSrc = DH_IMM;
      OP_INC:    begin st.dplSrc = DL_INC; st.zfWr = 1'b1; end
      OP_DEC:    begin st.dplSrc = DL_DEC; st.zfWr = 1'b1; end
      OP_SWAPA:  begin st.acSrc = AC_FROM_A; st.aWr = 1'b1; end
      OP_SWAPH:  begin st.dphSrc = DH_FROM_H; st.hWr = 1'b1; end
      OP_SWAPL:  begin st.dplSrc = DL_FROM_L; st.lWr = 1'b1; end
      OP_SWAPAH: begin st.acSrc = AC_FROM_DPH; st.dphSrc = DH_FROM_AC; end
      OP_AC2L:   st.dplSrc = DL_FROM_AC;
      OP_L2AC:   st.acSrc = AC_FROM_DPL;
      default:   ;
    endcase
  end

  // R12: codes outside the defined set must produce no write strobe
  always_comb begin
    if (opCode > 4'd10)
      a_r12_idle_strobes: assert (st.acSrc == AC_HOLD && st.dphSrc == DH_HOLD &&
                                  st.dplSrc == DL_HOLD && !st.aWr && !st.hWr &&
                                  !st.lWr && !st.zfWr);
  end
endmodule

// File: rtl/ptr_xchg_dp.sv
module ptr_xchg_dp
  import ptr_xchg_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int NA  = A_CNT,
  parameter int NHL = HL_CNT
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [1:0]        regSel,
  input  logic [DW-1:0]     immData,
  output logic [DW-1:0]     ac,
  output logic [DW-1:0]     dph,
  output logic [DW-1:0]     dpl,
  output logic [NA*DW-1:0]  aFlat,
  output logic [NHL*DW-1:0] hFlat,
  output logic [NHL*DW-1:0] lFlat,
  output logic              zf
);
  localparam int ASW = (NA > 1) ? $clog2(NA) : 1;
  localparam int HSW = (NHL > 1) ? $clog2(NHL) : 1;
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] aReg [NA];
  logic [DW-1:0] hReg [NHL];
  logic [DW-1:0] lReg [NHL];
  logic [ASW-1:0] aIdx;
  logic [HSW-1:0] hlIdx;
  logic [DW-1:0] aPick, hPick, lPick;
  logic [DW-1:0] acNext, dphNext, dplNext;

  assign aIdx  = regSel[ASW-1:0];
  assign hlIdx = regSel[HSW-1:0];
  assign aPick = aReg[aIdx];
  assign hPick = hReg[hlIdx];
  assign lPick = lReg[hlIdx];

  always_comb begin
    case (st.acSrc)
      AC_FROM_A:   acNext = aPick;
      AC_FROM_DPH: acNext = dph;
      AC_FROM_DPL: acNext = dpl;
      default:     acNext = ac;
    endcase
    case (st.dphSrc)
      DH_ZERO:    dphNext = '0;
      DH_IMM:     dphNext = immData;
      DH_FROM_AC: dphNext = ac;
      DH_FROM_H:  dphNext = hPick;
      default:    dphNext = dph;
    endcase
    case (st.dplSrc)
      DL_IMM:     dplNext = immData;
      DL_INC:     dplNext = dpl + ONE;
      DL_DEC:     dplNext = dpl - ONE;
      DL_FROM_AC: dplNext = ac;
      DL_FROM_L:  dplNext = lPick;
      default:    dplNext = dpl;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ac  <= '0;
      dph <= '0;
      dpl <= '0;
      zf  <= 1'b0;
    end else begin
      ac  <= acNext;
      dph <= dphNext;
      dpl <= dplNext;
      if (st.zfWr) zf <= (dplNext == '0);
    end
  end

  for (genvar i = 0; i < NA; i++) begin : g_aBank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) aReg[i] <= '0;
      else if (st.aWr && aIdx == ASW'(i)) aReg[i] <= ac;
    end
    assign aFlat[i*DW +: DW] = aReg[i];
  end

  for (genvar i = 0; i < NHL; i++) begin : g_hlBank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hReg[i] <= '0;
        lReg[i] <= '0;
      end else begin
        if (st.hWr && hlIdx == HSW'(i)) hReg[i] <= dph;
        if (st.lWr && hlIdx == HSW'(i)) lReg[i] <= dpl;
      end
    end
    assign hFlat[i*DW +: DW] = hReg[i];
    assign lFlat[i*DW +: DW] = lReg[i];
  end

  // R11: flag moves only under an increment or decrement strobe
  a_r11_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    !st.zfWr |=> $stable(zf));
  // R6, R13: accumulator swap lands both halves on the same edge
  a_r6_swap_both: assert property (@(posedge clk) disable iff (!rstN)
    st.aWr |=> (ac == $past(aPick)) && (aReg[$past(aIdx)] == $past(ac)));
endmodule

// File: rtl/ptr_xchg_unit.sv
module ptr_xchg_unit
  import ptr_xchg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [3:0]           opCode,
  input  logic [1:0]           regSel,
  input  logic [DATA_W-1:0]    immData,
  output logic [DATA_W-1:0]    acOut,
  output logic [DATA_W-1:0]    dphOut,
  output logic [DATA_W-1:0]    dplOut,
  output logic [A_CNT*DATA_W-1:0]  aRegs,
  output logic [HL_CNT*DATA_W-1:0] hRegs,
  output logic [HL_CNT*DATA_W-1:0] lRegs,
  output logic                 zeroFlag
);
  strobe_t st;

  ptr_xchg_ctrl u_ctrl (.opCode(opCode), .st(st));

  ptr_xchg_dp #(.DW(DATA_W), .NA(A_CNT), .NHL(HL_CNT)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .regSel(regSel), .immData(immData),
    .ac(acOut), .dph(dphOut), .dpl(dplOut),
    .aFlat(aRegs), .hFlat(hRegs), .lFlat(lRegs), .zf(zeroFlag)
  );

  a_r2_load_zero: assert property (@(posedge clk) disable iff (!rstN)
    opCode == OP_LOADZ |=> dphOut == '0 && dplOut == $past(immData));
  a_r3_load_high: assert property (@(posedge clk) disable iff (!rstN)
    opCode == OP_LOADH |=> dphOut == $past(immData) && $stable(dplOut));
  a_r4_increment: assert property (@(posedge clk) disable iff (!rstN)
    opCode == OP_INC |=> dplOut == DATA_W'($past(dplOut) + 1) && zeroFlag == (dplOut == '0));
  a_r5_decrement: assert property (@(posedge clk) disable iff (!rstN)
    opCode == OP_DEC |=> dplOut == DATA_W'($past(dplOut) - 1) && zeroFlag == (dplOut == '0));
  a_r9_swap_ac_dph: assert property (@(posedge clk) disable iff (!rstN)
    opCode == OP_SWAPAH |=> acOut == $past(dphOut) && dphOut == $past(acOut));
  a_r12_no_effect: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_NOP || opCode > 4'd10) |=> $stable(acOut) && $stable(dphOut) &&
      $stable(dplOut) && $stable(aRegs) && $stable(hRegs) && $stable(lRegs) && $stable(zeroFlag));
endmodule

// File: tb/ptr_xchg_unit_test.sv
module ptr_xchg_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] opCode = 4'd0;
  logic [1:0] regSel = 2'd0;
  logic [3:0] immData = 4'd0;
  logic [3:0] acOut, dphOut, dplOut;
  logic [15:0] aRegs;
  logic [7:0] hRegs, lRegs;
  logic zeroFlag;

  int compared = 0;
  int mismatched = 0;

  logic [3:0] mAc, mDph, mDpl;
  logic [3:0] mA [4];
  logic [3:0] mH [2];
  logic [3:0] mL [2];
  logic mZf;

  ptr_xchg_unit uut (.*);

  always #10 clk = ~clk;

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      4'd9, 4'd10: return "R10";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [15:0] packA();
    return {mA[3], mA[2], mA[1], mA[0]};
  endfunction

  task automatic modelStep(input logic [3:0] op, input logic [1:0] s, input logic [3:0] im);
    logic [3:0] t;
    case (op)
      4'd1: begin mDph = 4'd0; mDpl = im; end
      4'd2: mDph = im;
      4'd3: begin mDpl = mDpl + 4'd1; mZf = (mDpl == 4'd0); end
      4'd4: begin mDpl = mDpl - 4'd1; mZf = (mDpl == 4'd0); end
      4'd5: begin t = mAc; mAc = mA[s]; mA[s] = t; end
      4'd6: begin t = mDph; mDph = mH[s[0]]; mH[s[0]] = t; end
      4'd7: begin t = mDpl; mDpl = mL[s[0]]; mL[s[0]] = t; end
      4'd8: begin t = mAc; mAc = mDph; mDph = t; end
      4'd9: mDpl = mAc;
      4'd10: mAc = mDpl;
      default: ;
    endcase
  endtask

  task automatic checkAll(input string req);
    logic [48:0] act, exp;
    act = {acOut, dphOut, dplOut, aRegs, hRegs, lRegs, zeroFlag};
    exp = {mAc, mDph, mDpl, packA(), mH[1], mH[0], mL[1], mL[0], mZf};
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s (R13 state) actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic [3:0] op, input logic [1:0] s, input logic [3:0] im);
    opCode = op; regSel = s; immData = im;
    @(posedge clk);
    modelStep(op, s, im);
    @(negedge clk);
    // R11: zeroFlag is part of every comparison
    checkAll(reqOf(op));
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd4711;
    void'($urandom(seed));
    mAc = 0; mDph = 0; mDpl = 0; mZf = 0;
    for (int i = 0; i < 4; i++) mA[i] = 0;
    for (int i = 0; i < 2; i++) begin mH[i] = 0; mL[i] = 0; end
    repeat (3) @(negedge clk);
    checkAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // directed: R4 wrap from 15 onto zero, then leave zero
    doOp(4'd1, 2'd0, 4'd14);
    doOp(4'd3, 2'd0, 4'd0);
    doOp(4'd3, 2'd0, 4'd0);
    doOp(4'd3, 2'd0, 4'd0);
    // R5 wrap from 0 to 15, then back onto zero
    doOp(4'd1, 2'd0, 4'd0);
    doOp(4'd4, 2'd0, 4'd0);
    doOp(4'd3, 2'd0, 4'd0);
    // R11 flag holds across load, swap and copy
    doOp(4'd2, 2'd0, 4'd9);
    doOp(4'd10, 2'd0, 4'd0);
    doOp(4'd8, 2'd0, 4'd0);
    // fill spares, R7/R8 with regSel[1] high
    for (int i = 0; i < 4; i++) begin
      doOp(4'd1, 2'd0, 4'(i + 3));
      doOp(4'd10, 2'd0, 4'd0);
      doOp(4'd5, 2'(i), 4'd0);
    end
    doOp(4'd2, 2'd0, 4'd7);
    doOp(4'd6, 2'd3, 4'd0);
    doOp(4'd7, 2'd2, 4'd0);
    doOp(4'd6, 2'd1, 4'd0);
    doOp(4'd7, 2'd3, 4'd0);
    // R12 unused codes with noisy inputs
    for (int c = 11; c < 16; c++) doOp(4'(c), 2'd3, 4'hF);
    doOp(4'd0, 2'd2, 4'hA);

    // constrained random stream
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] op;
      op = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(11, 15)) : 4'($urandom_range(0, 10));
      doOp(op, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)));
    end
    finish();
  end

  task automatic finish();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    compared++;
    mismatched++;
    $display("FAIL watchdog R13 actual=hung expected=done");
    finish();
  end
endmodule